// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block buffers 36-bit words between a write clock and a read clock that need not be related in phase or frequency. Writes go into a memory array and a write pointer advances. Reads move words out of the array into an output register, and a read pointer advances each time a word lands there. Each side reads the other side's pointer through a chain of flip-flops clocked by its own clock. The pointers cross as Gray code with one wrap bit above the address bits.

The read side works in one of two timing modes, chosen at reset. In standard mode, `rdValid` shows that the array holds a readable word, and a read request moves it into `rdData`. In fall-through mode, the block loads the next word into `rdData` on its own, and `rdValid` shows that the register holds a word not yet consumed. In both modes, `wrReady` is high while at least one array location is free.

Top module: `dual_mode_fifo`

## Requirements
- R1: While the read-side reset is low, `rdValid` is 0 and `rdData` is 0. While the write-side reset is low, `wrReady` is 1. A reset clears both pointers, so the FIFO comes out of reset empty.
- R2: The mode is the value of `fwftSel` on the last read clock of reset: 1 selects fall-through, 0 selects standard. Changing `fwftSel` after reset has no effect until the next reset.
- R3: In standard mode, `rdValid` rises on the second rising `rdClk` edge after a write into an empty FIFO.
- R4: In standard mode, a rising `rdClk` edge with `rdEn` and `rdValid` both high loads the oldest stored word into `rdData`. Words come out in write order, and `rdValid` falls at once when that read empties the array.
- R5: In standard mode, `rdEn` while `rdValid` is low is ignored: `rdData` keeps the word from the previous read and the read pointer does not move. With `rdValid` high and `rdEn` low, `rdData` does not change.
- R6: In fall-through mode, a word written into an empty FIFO appears on `rdData` on the third rising `rdClk` edge after the write, and `rdValid` rises on that same edge.
- R7: In fall-through mode, an edge with `rdEn` and `rdValid` high consumes the word shown. If another word is stored, it loads on that same edge, so holding `rdEn` high drains one word per read clock. If none is stored, `rdValid` falls. With `rdEn` low, `rdValid` stays high.
- R8: In fall-through mode, `rdEn` while `rdValid` is low is ignored: `rdData` is unchanged and the read pointer does not move.
- R9: `wrReady` falls on the write edge that stores the DEPTH-th word. Writes made while `wrReady` is low are dropped and never appear at the read side.
- R10: After a read frees a location in a full FIFO, `wrReady` rises on the second rising `wrClk` edge after the read edge.
- R11: Word order is preserved when the pointers wrap around the array more than once, and each pointer's Gray form changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| wrRstN | input | 1 | Synchronous active-low reset, write side |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Word to store |
| wrReady | output | 1 | High while a location is free |
| rdClk | input | 1 | Read clock |
| rdRstN | input | 1 | Synchronous active-low reset, read side |
| fwftSel | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output register |
| rdValid | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |

## Verification
Each result has a fixed delay after its stimulus:
- A write shows up in standard mode two read edges later and in fall-through mode three read edges later.
- An accepted read changes `rdData` on the edge that accepts it.
- A read from a full FIFO raises `wrReady` two write edges later.

The bench offsets the read clock by half a period from the write clock, so every crossing has one known edge count. It samples the flags at the falling edge right after each edge where a result could change. For example, a flag still low after the first edge and high after the second pins the delay to exactly two edges. A scoreboard checks that data comes out in order on every edge that loads `rdData`.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
package tcf_pkg;

  // Strobes from control to datapath, one per clock domain.
  typedef struct packed {
    logic wrPush;   // write clock: store wrData at the write address
    logic rdLoad;   // read clock: move the addressed word into the output register
  } tcf_strobe_t;

endpackage

// File: rtl/tcf_sync.sv
`timescale 1ns/1ps
module tcf_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/tcf_ctrl.sv
`timescale 1ns/1ps
module tcf_ctrl
  import tcf_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  output logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              fwftSel,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output tcf_strobe_t       strobe
);

  localparam int PTR_W = ADDR_W + 1;
  // Full when write and read pointers differ only in the top two Gray bits.
  localparam logic [PTR_W-1:0] WRAP_MASK = {2'b11, {(PTR_W-2){1'b0}}};

  // ---------------- write clock domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, rdGraySync;
  logic             full, wrPush;

  tcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rstN(wrRstN),
    .din (rdGray),
    .dout(rdGraySync)
  );

  assign full      = (wrGray == (rdGraySync ^ WRAP_MASK));
  assign wrPush    = wrEn & ~full;
  assign wrBinNext = wrBin + 1'b1;

  always_ff @(posedge wrClk) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrPush) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  assign wrReady = ~full;
  assign wrAddr  = wrBin[ADDR_W-1:0];

  // ---------------- read clock domain ----------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, wrGraySync;
  logic             notEmpty, modeFwft, fwftValid, rdLoad;

  tcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rstN(rdRstN),
    .din (wrGray),
    .dout(wrGraySync)
  );

  assign notEmpty  = (wrGraySync != rdGray);
  assign rdBinNext = rdBin + 1'b1;

  // Fall-through reloads when the register is free or is being consumed.
  always_comb begin
    if (modeFwft) rdLoad = notEmpty & (~fwftValid | rdEn);
    else          rdLoad = notEmpty & rdEn;
  end

  // The mode follows fwftSel while reset is held, so the last reset cycle wins.
  always_ff @(posedge rdClk) begin
    if (!rdRstN) modeFwft <= fwftSel;
  end

  always_ff @(posedge rdClk) begin
    if (!rdRstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      fwftValid <= 1'b0;
    end else begin
      if (rdLoad) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
      if (modeFwft) begin
        if (rdLoad)    fwftValid <= 1'b1;
        else if (rdEn) fwftValid <= 1'b0;
      end
    end
  end

  assign rdValid = modeFwft ? fwftValid : notEmpty;
  assign rdAddr  = rdBin[ADDR_W-1:0];

  assign strobe.wrPush = wrPush;
  assign strobe.rdLoad = rdLoad;

  // ---------------- assertions ----------------
  p_wr_gray_step_r11: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $onehot0(wrGray ^ $past(wrGray)));

  p_rd_gray_step_r11: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $onehot0(rdGray ^ $past(rdGray)));

  p_full_block_r9: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && !wrReady) |=> $stable(wrBin));

  p_mode_hold_r2: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $stable(modeFwft));

  p_std_ignore_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!modeFwft && rdEn && !rdValid) |=> $stable(rdBin));

  p_no_underflow_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!notEmpty) |=> $stable(rdBin));

  p_fwft_keep_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (modeFwft && rdValid && !rdEn) |=> rdValid);

endmodule

// File: rtl/tcf_store.sv
`timescale 1ns/1ps
module tcf_store
  import tcf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  tcf_strobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strobe.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (!rdRstN)            outReg <= '0;
    else if (strobe.rdLoad) outReg <= mem[rdAddr];
  end

  assign rdData = outReg;

endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo
  import tcf_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              fwftSel,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  tcf_strobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  tcf_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk  (wrClk),
    .wrRstN (wrRstN),
    .wrEn   (wrEn),
    .wrReady(wrReady),
    .wrAddr (wrAddr),
    .rdClk  (rdClk),
    .rdRstN (rdRstN),
    .fwftSel(fwftSel),
    .rdEn   (rdEn),
    .rdValid(rdValid),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  tcf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk (wrClk),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdClk (rdClk),
    .rdRstN(rdRstN),
    .rdAddr(rdAddr),
    .strobe(strobe),
    .rdData(rdData)
  );

  // A shown word with no read request stays put in either mode.
  p_hold_data_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && !rdEn) |=> $stable(rdData));

endmodule

// File: tb/dual_mode_fifo_test.sv
`timescale 1ns/1ps
module dual_mode_fifo_test;

  localparam int DW    = 36;
  localparam int DEPTH = 16;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic wrRstN, rdRstN, wrEn, rdEn, fwftSel;
  logic [DW-1:0] wrData, rdData;
  logic wrReady, rdValid;

  always #2 wrClk = ~wrClk;
  initial begin
    #2;
    forever #2 rdClk = ~rdClk;
  end

  dual_mode_fifo uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrReady(wrReady),
    .rdClk(rdClk), .rdRstN(rdRstN), .fwftSel(fwftSel), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] expQ[$];
  bit benchFwft = 1'b0;
  bit monOn = 1'b0;
  bit monAcc, monWasV;
  logic [DW-1:0] monExp;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor: compares every word that lands in rdData.
  initial begin
    forever begin
      @(posedge rdClk);
      monAcc  = rdEn && rdValid;
      monWasV = rdValid;
      @(negedge rdClk);
      if (monOn && rdRstN) begin
        if ((!benchFwft && monAcc) || (benchFwft && rdValid && (!monWasV || monAcc))) begin
          if (expQ.size() == 0) begin
            check(1'b0, benchFwft ? "R7 unexpected word" : "R4 unexpected word", rdData, '0);
          end else begin
            monExp = expQ.pop_front();
            check(rdData == monExp, benchFwft ? "R7 data order" : "R4 data order", rdData, monExp);
          end
        end
      end
    end
  end

  task automatic doReset(input bit fwft);
    monOn   = 1'b0;
    wrRstN  = 1'b0;
    rdRstN  = 1'b0;
    wrEn    = 1'b0;
    rdEn    = 1'b0;
    wrData  = '0;
    fwftSel = fwft;
    repeat (4) @(negedge wrClk);
    check(rdValid == 1'b0, "R1 rdValid in reset", DW'(rdValid), '0);
    check(wrReady == 1'b1, "R1 wrReady in reset", DW'(wrReady), 1);
    @(negedge rdClk) rdRstN = 1'b1;
    @(negedge wrClk) wrRstN = 1'b1;
    expQ.delete();
    benchFwft = fwft;
    monOn = 1'b1;
  endtask

  task automatic writeWord(input logic [DW-1:0] d);
    @(negedge wrClk);
    wrEn = 1'b1;
    wrData = d;
    if (wrReady) expQ.push_back(d);
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic writeBurst(input int n, input logic [DW-1:0] base);
    @(negedge wrClk);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1;
      wrData = base + DW'(i);
      if (wrReady) expQ.push_back(wrData);
      @(negedge wrClk);
    end
    wrEn = 1'b0;
  endtask

  task automatic readOnce();
    @(negedge rdClk) rdEn = 1'b1;
    @(negedge rdClk) rdEn = 1'b0;
  endtask

  task automatic drain(input int cycles);
    @(negedge rdClk) rdEn = 1'b1;
    repeat (cycles) @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  initial begin
    #(800000);
    check(1'b0, "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin
    // ---------- standard mode ----------
    doReset(1'b0);
    fwftSel = 1'b1;  // R2: must be ignored until the next reset
    check(rdValid == 1'b0, "R1 rdValid after reset", DW'(rdValid), '0);
    check(wrReady == 1'b1, "R1 wrReady after reset", DW'(wrReady), 1);
    check(rdData == '0, "R1 rdData after reset", rdData, '0);

    writeWord(36'h1_2345_6789);
    @(negedge rdClk);
    check(rdValid == 1'b0, "R3 rdValid one edge after write", DW'(rdValid), '0);
    @(negedge rdClk);
    check(rdValid == 1'b1, "R3 rdValid two edges after write", DW'(rdValid), 1);
    check(rdData == '0, "R2 standard mode kept, no fall-through", rdData, '0);

    readOnce();
    check(rdData == 36'h1_2345_6789, "R4 read loads word", rdData, 36'h1_2345_6789);
    check(rdValid == 1'b0, "R4 rdValid falls when emptied", DW'(rdValid), '0);

    readOnce();  // empty: ignored
    check(rdData == 36'h1_2345_6789, "R5 ignored read keeps rdData", rdData, 36'h1_2345_6789);
    check(rdValid == 1'b0, "R5 still empty", DW'(rdValid), '0);
    writeWord(36'hB_0000_000B);
    repeat (3) @(negedge rdClk);
    readOnce();
    check(rdData == 36'hB_0000_000B, "R5 pointer unmoved by ignored read", rdData, 36'hB_0000_000B);

    // full handling
    writeBurst(DEPTH, 36'hA_0000_0000);
    check(wrReady == 1'b0, "R9 wrReady low after DEPTH words", DW'(wrReady), '0);
    writeWord(36'hD_EAD0_0000);  // dropped
    check(wrReady == 1'b0, "R9 still full after dropped write", DW'(wrReady), '0);
    repeat (4) @(negedge rdClk);
    readOnce();
    @(negedge wrClk);
    check(wrReady == 1'b0, "R10 wrReady one edge after read", DW'(wrReady), '0);
    @(negedge wrClk);
    check(wrReady == 1'b1, "R10 wrReady two edges after read", DW'(wrReady), 1);
    drain(DEPTH + 3);
    check(rdValid == 1'b0, "R9 empty after drain", DW'(rdValid), '0);
    check(expQ.size() == 0, "R9 dropped word never read", DW'(expQ.size()), '0);

    // wrap-around
    for (int rep = 0; rep < 4; rep++) begin
      writeBurst(12, 36'h5_0000_0000 + DW'(rep * 256));
      repeat (4) @(negedge rdClk);
      drain(15);
      check(expQ.size() == 0, "R11 all words out after wrap", DW'(expQ.size()), '0);
    end

    // ---------- fall-through mode ----------
    doReset(1'b1);
    fwftSel = 1'b0;  // R2: must be ignored
    check(rdValid == 1'b0, "R1 rdValid after reset (fwft)", DW'(rdValid), '0);
    check(rdData == '0, "R1 rdData after reset (fwft)", rdData, '0);

    readOnce();  // empty: ignored
    check(rdData == '0, "R8 ignored read keeps rdData", rdData, '0);
    check(rdValid == 1'b0, "R8 rdValid stays low", DW'(rdValid), '0);

    writeWord(36'hC_0FFE_E000);
    @(negedge rdClk);
    check(rdValid == 1'b0, "R6 rdValid one edge after write", DW'(rdValid), '0);
    @(negedge rdClk);
    check(rdValid == 1'b0, "R6 rdValid two edges after write", DW'(rdValid), '0);
    @(negedge rdClk);
    check(rdValid == 1'b1, "R6 rdValid three edges after write", DW'(rdValid), 1);
    check(rdData == 36'hC_0FFE_E000, "R2 fall-through mode kept; R6 word shown", rdData, 36'hC_0FFE_E000);

    writeBurst(6, 36'h7_0000_0000);
    repeat (6) @(negedge rdClk);
    check(rdData == 36'hC_0FFE_E000, "R7 word held without rdEn", rdData, 36'hC_0FFE_E000);
    @(negedge rdClk) rdEn = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge rdClk);
      check(rdValid == (i < 6), "R7 back-to-back rdValid", DW'(rdValid), DW'(i < 6));
    end
    rdEn = 1'b0;
    check(expQ.size() == 0, "R7 all words drained", DW'(expQ.size()), '0);

    repeat (4) @(negedge rdClk);
    finishRun();
  end

endmodule